// File: doc/BRIEF.md
# Transmit DMA Channel Control and Status Bank

This block holds the control registers of a bank of transmit DMA channels and runs one small mode state machine per channel. Software reaches it through a 32-bit register port. Each channel owns a 0x20-byte window that holds three registers: a configuration word, a credit word and a read-only buffer-status word. From its configuration word each channel drives three signals to the data path: a run strobe, a paused flag and a request enable. Descriptor fetch and data movement live in the data path and are not part of this block.

The data path reports two conditions for each channel: its buffers are empty, and it has no request outstanding. The block packs both lanes for every channel into one shared status word. Software uses that word to find out when a stopped channel has become idle. A channel can stop at once, or it can keep running until the end of the current frame. In the second case it stops when the data path signals the last transfer of that frame.

The per-channel state machine has three states. STOPPED means no requests are issued and the paused flag is high. RUNNING means normal operation. DRAINING means a pause at end of frame has been requested and the frame is still in flight. The transitions are START (STOPPED to RUNNING, mode 10 written), ABORT (any state to STOPPED, mode 00 or 11 written), DRAIN_BEGIN (RUNNING to DRAINING, mode 01 while no end-of-frame is signalled), DRAIN_DONE (RUNNING or DRAINING to STOPPED, mode 01 with end-of-frame signalled), RESUME (DRAINING to RUNNING, mode 10 written) and HOLD (any state keeps its value). A mode change takes effect at the same clock edge that stores the configuration write.

Top module: `txdma_ctrl_bank`

## Requirements
- R1: After reset, every channel is STOPPED. ch_pause is all ones, ch_run and ch_req_en are all zeros, every credit word is zero, and reg_rdata is zero.
- R2: The configuration word of channel c is at WIN_BASE + 0x20*c (default base 0x100). Bits 31:30 hold the mode and bit 3 holds the request enable. Both read back as written, in the cycle after the read strobe.
- R3: Reserved configuration bits (29:4 and 2:0) are not stored and always read as zero. A configuration read returns the written data ANDed with 0xC0000008.
- R4: A write of mode 10 puts the channel in RUNNING at that edge. ch_run is high exactly when the channel is RUNNING and its bit 3 is set.
- R5: A write of mode 00 or 11 puts the channel in STOPPED at that edge. In STOPPED, ch_pause is high and ch_req_en is low.
- R6: A write of mode 01 to a RUNNING channel moves it to DRAINING. The channel stays in DRAINING, with requests still enabled, until ch_eof is high in a cycle, and then goes to STOPPED at that edge. If ch_eof is already high in the cycle of the write, the channel stops at once. Mode 01 written to a STOPPED channel leaves it stopped.
- R7: ch_req_en is high exactly when the channel is RUNNING or DRAINING and its bit 3 is set.
- R8: tx_status bits 24+c carry ch_empty[c], bits 16+c carry ch_nopend[c], and all other bits are zero. The same word reads back at STS_ADDR (default 0x300).
- R9: ch_idle[c] is high only when both ch_empty[c] and ch_nopend[c] are high.
- R10: The credit word at offset 0x4 stores and returns bits 15:0 (upper bits read zero). The buffer-status word at offset 0x8 returns bit 0 = buffers empty, bit 1 = no pending request, bit 2 = channel STOPPED, and zero elsewhere.
- R11: Writes to the buffer-status word, to any other offset in a window, to STS_ADDR or outside the bank change nothing. Reads of undefined addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (12) | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| ch_empty | input | NUM_CH (8) | Per-channel buffers-empty indication |
| ch_nopend | input | NUM_CH (8) | Per-channel no-request-pending indication |
| ch_eof | input | NUM_CH (8) | Per-channel last transfer of current frame completes |
| ch_run | output | NUM_CH (8) | Channel running normally with requests enabled |
| ch_pause | output | NUM_CH (8) | Channel stopped |
| ch_req_en | output | NUM_CH (8) | Channel may issue DMA requests |
| ch_idle | output | NUM_CH (8) | Buffers empty and no request pending |
| tx_status | output | 32 | Shared packed status word |

## Verification
The hardest state to reach is a channel held in DRAINING while the stimulus keeps changing. This needs a mode 01 write that lands on a RUNNING channel in a cycle where that channel's end-of-frame input is low. The channel must then sit for several cycles without end-of-frame, and it may be resumed or aborted before the frame ends. The random phase biases written modes toward 10 and 01 and drives ch_eof only one cycle in four, so that drains last long enough to be seen. A directed sequence also holds one channel in DRAINING for several cycles and checks the exact edge at which it stops.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } ch_state_t;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_CFG  = 2'd1,
        K_CRED = 2'd2,
        K_BSTS = 2'd3
    } reg_kind_t;

    localparam logic [1:0] MODE_OFF = 2'b00;
    localparam logic [1:0] MODE_EOF = 2'b01;
    localparam logic [1:0] MODE_RUN = 2'b10;

    localparam int MODE_LSB   = 30;
    localparam int REQEN_BIT  = 3;
    localparam int EMPTY_LSB  = 24;
    localparam int NOPEND_LSB = 16;

    localparam int OFF_CFG  = 0;
    localparam int OFF_CRED = 4;
    localparam int OFF_BSTS = 8;
endpackage

// File: rtl/txdma_addr_dec.sv
module txdma_addr_dec
    import txdma_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_CH    = 8,
    parameter int CH_STRIDE = 32,
    parameter int WIN_BASE  = 'h100,
    parameter int STS_ADDR  = 'h300
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ch_hit,
    output reg_kind_t         kind,
    output logic              sts_hit
);
    localparam int STRIDE_LG = $clog2(CH_STRIDE);
    localparam int IDX_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int WIN_TOP   = WIN_BASE + NUM_CH * CH_STRIDE;

    logic [ADDR_W-1:0]    rel;
    logic [IDX_W-1:0]     idx;
    logic [STRIDE_LG-1:0] off;
    logic                 in_win;

    assign rel     = addr - ADDR_W'(WIN_BASE);
    assign idx     = IDX_W'(rel >> STRIDE_LG);
    assign off     = rel[STRIDE_LG-1:0];
    assign in_win  = (addr >= ADDR_W'(WIN_BASE)) && (addr < ADDR_W'(WIN_TOP));
    assign sts_hit = (addr == ADDR_W'(STS_ADDR));

    always_comb begin
        kind = K_NONE;
        if (in_win) begin
            if (off == STRIDE_LG'(OFF_CFG))       kind = K_CFG;
            else if (off == STRIDE_LG'(OFF_CRED)) kind = K_CRED;
            else if (off == STRIDE_LG'(OFF_BSTS)) kind = K_BSTS;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
        assign ch_hit[g] = in_win && (idx == IDX_W'(g));
    end

    always_comb begin
        if (!$isunknown(addr)) begin
            assert_hit_onehot_R2: assert ($onehot0(ch_hit));
            assert_sts_outside_R11: assert (!(sts_hit && in_win));
        end
    end
endmodule

// File: rtl/txdma_chan.sv
module txdma_chan
    import txdma_pkg::*;
#(
    parameter int CREDIT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic        cred_wr,
    input  logic [31:0] wdata,
    input  logic        eof_i,
    input  logic        empty_i,
    input  logic        nopend_i,
    output logic        run_o,
    output logic        pause_o,
    output logic        req_o,
    output logic [31:0] cfg_rd,
    output logic [31:0] cred_rd,
    output logic [31:0] bsts_rd
);
    ch_state_t             state_q, state_d;
    logic [1:0]            mode_q, mode_nx;
    logic                  reqen_q;
    logic [CREDIT_W-1:0]   cred_q;
    logic                  unused_wd;

    assign unused_wd = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= MODE_OFF;
            reqen_q <= 1'b0;
            cred_q  <= '0;
        end else begin
            if (cfg_wr) begin
                mode_q  <= wdata[MODE_LSB +: 2];
                reqen_q <= wdata[REQEN_BIT];
            end
            if (cred_wr) cred_q <= wdata[CREDIT_W-1:0];
        end
    end

    assign mode_nx = cfg_wr ? wdata[MODE_LSB +: 2] : mode_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (mode_nx == MODE_RUN) state_d = ST_RUN;
            end
            ST_RUN, ST_DRAIN: begin
                if (mode_nx == MODE_RUN)      state_d = ST_RUN;
                else if (mode_nx == MODE_EOF) state_d = eof_i ? ST_STOP : ST_DRAIN;
                else                          state_d = ST_STOP;
            end
            default: state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        run_o   = 1'b0;
        pause_o = 1'b0;
        req_o   = 1'b0;
        unique case (state_q)
            ST_STOP:  pause_o = 1'b1;
            ST_RUN: begin
                run_o = reqen_q;
                req_o = reqen_q;
            end
            ST_DRAIN: req_o = reqen_q;
            default:  pause_o = 1'b1;
        endcase
    end

    always_comb begin
        cfg_rd                  = '0;
        cfg_rd[MODE_LSB +: 2]   = mode_q;
        cfg_rd[REQEN_BIT]       = reqen_q;
        cred_rd                 = 32'(cred_q);
        bsts_rd                 = {29'b0, pause_o, nopend_i, empty_i};
    end

    assert_wr_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && wdata[MODE_LSB +: 2] == MODE_RUN |=> state_q == ST_RUN);
    assert_wr_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !wdata[MODE_LSB] && !(wdata[MODE_LSB+1] ^ wdata[MODE_LSB])
        |=> pause_o && !req_o);
    assert_drain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DRAIN && !eof_i && !cfg_wr |=> state_q == ST_DRAIN && $stable(req_o));
    assert_drain_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DRAIN && eof_i && !cfg_wr |=> pause_o);
    assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pause_o |-> !req_o && !run_o);
    assert_credit_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cred_wr |=> $stable(cred_q));
endmodule

// File: rtl/txdma_sts_pack.sv
module txdma_sts_pack
    import txdma_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] empty_i,
    input  logic [NUM_CH-1:0] nopend_i,
    output logic [NUM_CH-1:0] idle_o,
    output logic [31:0]       word_o
);
    always_comb begin
        word_o                       = '0;
        word_o[EMPTY_LSB +: NUM_CH]  = empty_i;
        word_o[NOPEND_LSB +: NUM_CH] = nopend_i;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_idle
        assign idle_o[g] = empty_i[g] & nopend_i[g];
    end
endmodule

// File: rtl/txdma_ctrl_bank.sv
module txdma_ctrl_bank
    import txdma_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_CH    = 8,
    parameter int CH_STRIDE = 32,
    parameter int WIN_BASE  = 'h100,
    parameter int STS_ADDR  = 'h300,
    parameter int CREDIT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_CH-1:0] ch_empty,
    input  logic [NUM_CH-1:0] ch_nopend,
    input  logic [NUM_CH-1:0] ch_eof,
    output logic [NUM_CH-1:0] ch_run,
    output logic [NUM_CH-1:0] ch_pause,
    output logic [NUM_CH-1:0] ch_req_en,
    output logic [NUM_CH-1:0] ch_idle,
    output logic [31:0]       tx_status
);
    logic [NUM_CH-1:0] ch_hit;
    reg_kind_t         kind;
    logic              sts_hit;
    logic [31:0]       cfg_rd  [NUM_CH];
    logic [31:0]       cred_rd [NUM_CH];
    logic [31:0]       bsts_rd [NUM_CH];
    logic [31:0]       rd_val;

    txdma_addr_dec #(
        .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_STRIDE(CH_STRIDE),
        .WIN_BASE(WIN_BASE), .STS_ADDR(STS_ADDR)
    ) u_dec (
        .addr(reg_addr), .ch_hit(ch_hit), .kind(kind), .sts_hit(sts_hit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        txdma_chan #(.CREDIT_W(CREDIT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_wr  (reg_wr && ch_hit[g] && kind == K_CFG),
            .cred_wr (reg_wr && ch_hit[g] && kind == K_CRED),
            .wdata   (reg_wdata),
            .eof_i   (ch_eof[g]),
            .empty_i (ch_empty[g]),
            .nopend_i(ch_nopend[g]),
            .run_o   (ch_run[g]),
            .pause_o (ch_pause[g]),
            .req_o   (ch_req_en[g]),
            .cfg_rd  (cfg_rd[g]),
            .cred_rd (cred_rd[g]),
            .bsts_rd (bsts_rd[g])
        );
    end

    txdma_sts_pack #(.NUM_CH(NUM_CH)) u_sts (
        .empty_i(ch_empty), .nopend_i(ch_nopend), .idle_o(ch_idle), .word_o(tx_status)
    );

    always_comb begin
        rd_val = '0;
        if (sts_hit) rd_val = tx_status;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_hit[i]) begin
                case (kind)
                    K_CFG:   rd_val = cfg_rd[i];
                    K_CRED:  rd_val = cred_rd[i];
                    K_BSTS:  rd_val = bsts_rd[i];
                    default: rd_val = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_val;
    end

    assert_sts_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && sts_hit |=> reg_rdata == $past(tx_status));
    assert_undef_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && !sts_hit && ch_hit == '0 |=> reg_rdata == 32'd0);
endmodule

// File: tb/sim_txdma_ctrl_bank.sv
module sim_txdma_ctrl_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NCH-1:0] ch_empty = '0, ch_nopend = '0, ch_eof = '0;
    logic [NCH-1:0] ch_run, ch_pause, ch_req_en, ch_idle;
    logic [31:0] tx_status;

    int checks = 0, errors = 0;
    bit done = 0;

    int          m_st   [NCH];
    logic [1:0]  m_mode [NCH];
    logic        m_req  [NCH];
    logic [15:0] m_cred [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    txdma_ctrl_bank u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ch_empty(ch_empty), .ch_nopend(ch_nopend), .ch_eof(ch_eof),
        .ch_run(ch_run), .ch_pause(ch_pause), .ch_req_en(ch_req_en),
        .ch_idle(ch_idle), .tx_status(tx_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int nxt(int st, logic [1:0] md, logic eof);
        if (md == 2'b10) return 1;
        if (md == 2'b01) return (st == 0 || eof) ? 0 : 2;
        return 0;
    endfunction

    function automatic logic [31:0] exp_status();
        return {ch_empty, ch_nopend, 16'h0};
    endfunction

    function automatic logic [31:0] exp_rd(logic [11:0] a);
        int c, o;
        if (a == 12'h300) return exp_status();
        if (a < 12'h100 || a >= 12'h200) return 32'h0;
        c = int'((a - 12'h100) >> 5);
        o = int'(a[4:0]);
        if (o == 0) return {m_mode[c], 26'h0, m_req[c], 3'b0};
        if (o == 4) return {16'h0, m_cred[c]};
        if (o == 8) return {29'h0, (m_st[c] == 0), ch_nopend[c], ch_empty[c]};
        return 32'h0;
    endfunction

    function automatic string tag_of(logic [11:0] a);
        if (a == 12'h300) return "R8";
        if (a < 12'h100 || a >= 12'h200) return "R11";
        if (a[4:0] == 5'd0) return "R2/R3";
        if (a[4:0] == 5'd4 || a[4:0] == 5'd8) return "R10";
        return "R11";
    endfunction

    task automatic check_outputs();
        logic [NCH-1:0] e_run, e_pause, e_req;
        for (int c = 0; c < NCH; c++) begin
            e_run[c]   = (m_st[c] == 1) && m_req[c];
            e_req[c]   = (m_st[c] != 0) && m_req[c];
            e_pause[c] = (m_st[c] == 0);
        end
        chk("R4", 32'(ch_run), 32'(e_run));
        chk("R7", 32'(ch_req_en), 32'(e_req));
        chk("R5", 32'(ch_pause), 32'(e_pause));
        chk("R9", 32'(ch_idle), 32'(ch_empty & ch_nopend));
        chk("R8", tx_status, exp_status());
    endtask

    task automatic step(input bit w, input bit r, input logic [11:0] a, input logic [31:0] d);
        logic [31:0] erd;
        string       rtag;
        int          wc;
        bit          in_win;
        reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
        erd = exp_rd(a);
        rtag = tag_of(a);
        in_win = (a >= 12'h100 && a < 12'h200);
        wc = in_win ? int'((a - 12'h100) >> 5) : -1;
        for (int c = 0; c < NCH; c++) begin
            logic [1:0] nm;
            nm = m_mode[c];
            if (w && c == wc && a[4:0] == 5'd0) begin
                nm = d[31:30];
                m_req[c] = d[3];
            end
            if (w && c == wc && a[4:0] == 5'd4) m_cred[c] = d[15:0];
            m_st[c] = nxt(m_st[c], nm, ch_eof[c]);
            m_mode[c] = nm;
        end
        @(posedge clk); #2;
        reg_wr = 1'b0; reg_rd = 1'b0;
        check_outputs();
        if (r) chk(rtag, reg_rdata, erd);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_st[c] = 0; m_mode[c] = 2'b00; m_req[c] = 1'b0; m_cred[c] = '0;
        end
        void'($urandom(32'd24680));
        repeat (3) @(posedge clk);
        #2;
        chk("R1", 32'(ch_pause), 32'hFF);
        chk("R1", 32'(ch_run), 32'h0);
        chk("R1", 32'(ch_req_en), 32'h0);
        chk("R1", reg_rdata, 32'h0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        step(0, 1, 12'h124, 0);                      // R1 credit zero
        chk("R1", reg_rdata, 32'h0);

        // R2/R3: all-ones write to channel 3, readback masked
        step(1, 0, 12'h160, 32'hFFFF_FFFF);
        step(0, 1, 12'h160, 0);
        chk("R3", reg_rdata, 32'hC000_0008);
        // mode 11 counts as stop (R5)
        chk("R5", 32'(ch_pause[3]), 32'h1);

        // R4: start channel 0 with requests
        step(1, 0, 12'h100, 32'h8000_0008);
        chk("R4", 32'(ch_run[0]), 32'h1);
        // R4: running without bit 3
        step(1, 0, 12'h100, 32'h8000_0000);
        chk("R4", 32'(ch_run[0]), 32'h0);
        chk("R7", 32'(ch_req_en[0]), 32'h0);

        // R6: drain channel 2
        step(1, 0, 12'h140, 32'h8000_0008);
        step(1, 0, 12'h140, 32'h4000_0008);
        for (int k = 0; k < 4; k++) begin
            step(0, 0, 12'h0, 0);
            chk("R6", {ch_req_en[2], ch_run[2], ch_pause[2]}, 32'b100);
        end
        ch_eof[2] = 1'b1;
        step(0, 0, 12'h0, 0);
        ch_eof[2] = 1'b0;
        chk("R6", {ch_req_en[2], ch_pause[2]}, 32'b01);
        step(1, 0, 12'h140, 32'h4000_0008);
        chk("R6", 32'(ch_pause[2]), 32'h1);

        // R10: credit and buffer-status
        step(1, 0, 12'h1E4, 32'hABCD_1234);
        step(0, 1, 12'h1E4, 0);
        chk("R10", reg_rdata, 32'h0000_1234);
        ch_empty = 8'h81; ch_nopend = 8'h80;
        step(0, 1, 12'h1E8, 0);
        chk("R10", reg_rdata, 32'h0000_0007);

        // R11: ignored writes
        step(1, 0, 12'h1E8, 32'hFFFF_FFFF);
        step(1, 0, 12'h10C, 32'h8000_0008);
        step(1, 0, 12'h300, 32'h8000_0008);
        step(1, 0, 12'h050, 32'h8000_0008);
        step(0, 1, 12'h100, 0);
        chk("R11", reg_rdata, 32'h8000_0000);
        step(0, 1, 12'h050, 0);
        chk("R11", reg_rdata, 32'h0);

        // R8: status readback
        ch_empty = 8'h5A; ch_nopend = 8'h3C;
        step(0, 1, 12'h300, 0);
        chk("R8", reg_rdata, 32'h5A3C_0000);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int sel;
            logic [11:0] a;
            logic [31:0] d;
            ch_empty  = 8'($urandom);
            ch_nopend = 8'($urandom);
            for (int c = 0; c < NCH; c++) ch_eof[c] = ($urandom % 4) == 0;
            sel = $urandom % 10;
            case ($urandom % 8)
                0, 1, 2, 3: a = 12'h100 + 12'(($urandom % 8) * 32);
                4: a = 12'h104 + 12'(($urandom % 8) * 32);
                5: a = 12'h108 + 12'(($urandom % 8) * 32);
                6: a = 12'h10C + 12'(($urandom % 8) * 32) + 12'($urandom % 16);
                default: a = ($urandom % 2) ? 12'h300 : 12'($urandom);
            endcase
            d = $urandom;
            case ($urandom % 6)
                0, 1: d[31:30] = 2'b10;
                2, 3: d[31:30] = 2'b01;
                default: ;
            endcase
            if (sel < 4)      step(1, 0, a, d);
            else if (sel < 7) step(0, 1, a, 0);
            else              step(0, 0, a, 0);
        end
        ch_eof = '0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule